// File: doc/BRIEF.md
# Indexed Interrupt Level Register

This block is a single write register that steers a level onto one line of a bank of level-sensitive interrupt outputs. There is one output line for each attached processor, and the line count is a parameter. Each accepted write carries two bytes: a line index and the level to drive onto that line. Only the selected line takes the new level. Every other line keeps the value it already holds. By convention, line N feeds the external interrupt input of processor N.

The write side is a valid/ready stream of bus writes. Each beat carries an address, two byte enables and sixteen bits of data. The block never applies back-pressure: `wr_ready` is always high, so a beat is consumed in any cycle where `wr_valid` is high. A beat that does not decode to the register is consumed and has no effect. The block stores a full 8-bit level per line and drives the line high whenever that level is nonzero. A plain combinational port reads back the stored level of any line. If a write names a line that does not exist, the block raises an error pulse and stores nothing.

Top module: `irqlvl_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, all `irq_lines` are 0 and `err_pulse` is 0. After reset, every stored level reads back as 0.
- R2: A beat is decoded only when `wr_valid` is 1 and `wr_addr & 0x3f` equals 8. Address bits above bit 5 are ignored. A beat at any other offset changes no output.
- R3: The lane at the lower byte address is `wr_data[15:8]` with enable `wr_be[1]`, and it carries the line index. The lane at the higher byte address is `wr_data[7:0]` with enable `wr_be[0]`, and it carries the level. For example, data 0x0102 with both enables set drives level 2 onto line 1.
- R4: A decoded beat with `wr_be[1]`=1 and `wr_be[0]`=0 stores level 0 on the selected line. A decoded beat with `wr_be[1]`=0 is ignored.
- R5: An accepted write stores its level on line `idx`. In the cycle after the accepting clock edge, `irq_lines[idx]` equals 1 if the level is nonzero and 0 otherwise. All other lines keep their stored levels until a later write to them.
- R6: A decoded beat with `wr_be[1]`=1 and index >= `NUM_LINES` changes no line. It makes `err_pulse` 1 for exactly the one cycle that follows that edge. `err_pulse` is 0 in every cycle that does not follow such a beat.
- R7: `rd_level` combinationally returns the stored level of line `rd_idx`, or 0 when `rd_idx` >= `NUM_LINES`. In the cycle of a write to the same line, it still shows the old level.
- R8: `wr_ready` is 1 at all times, so the write stream never back-pressures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write beat present |
| wr_ready | output | 1 | Always 1; write beat consumed |
| wr_addr | input | ADDR_W | Byte address of the beat |
| wr_be | input | 2 | Byte enables: [1] index lane, [0] level lane |
| wr_data | input | 16 | [15:8] line index, [7:0] level |
| rd_idx | input | 8 | Line selected for level readback |
| rd_level | output | 8 | Stored level of line `rd_idx` |
| irq_lines | output | NUM_LINES | Per-line interrupt level, 1 when stored level nonzero |
| err_pulse | output | 1 | One-cycle pulse after an out-of-range index |

## Verification
Two functions can fall in the same cycle: a write to a line and a readback of that same line. The bench provokes this on every write of its sweep by pointing `rd_idx` at the written index while the beat is still on the bus. Before the edge, it expects the previous level from its own model of stored levels. After the edge, it expects the new level. The sweep covers the following:
- every index inside and outside the four-line configuration;
- four addresses, including an alias above the 64-byte window;
- every byte-enable pattern;
- asserted and idle `wr_valid`.

// File: rtl/irqlvl_pkg.sv
package irqlvl_pkg;
  localparam int BYTE_W     = 8;
  localparam int DATA_W     = 2 * BYTE_W;
  localparam int BE_W       = DATA_W / BYTE_W;
  localparam int LANE_INDEX = 1;   // lower byte address, big-endian lane
  localparam int LANE_LEVEL = 0;   // higher byte address
  localparam int WIN_MASK   = 'h3f;
  localparam int MAX_LINES  = 256; // index byte bounds the bank

  typedef logic [BYTE_W-1:0] byte_t;

  typedef struct packed {
    logic  apply;   // in-range write to store
    logic  bad;     // decoded write with out-of-range index
    byte_t idx;
    byte_t lvl;
  } lvl_cmd_t;
endpackage

// File: rtl/irqlvl_decode.sv
module irqlvl_decode
  import irqlvl_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int ADDR_W    = 12,
  parameter int REG_OFS   = 8
) (
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [DATA_W-1:0] data_i,
  output lvl_cmd_t          cmd_o
);
  localparam logic [ADDR_W-1:0] MASK = ADDR_W'(WIN_MASK);
  localparam logic [ADDR_W-1:0] OFS  = ADDR_W'(REG_OFS);

  logic  hit;
  logic  idx_ok;
  byte_t idx_b;
  byte_t lvl_b;

  always_comb begin
    hit    = valid_i && ((addr_i & MASK) == OFS) && be_i[LANE_INDEX];
    idx_b  = data_i[LANE_INDEX*BYTE_W +: BYTE_W];
    lvl_b  = be_i[LANE_LEVEL] ? data_i[LANE_LEVEL*BYTE_W +: BYTE_W] : '0;
    idx_ok = 32'(idx_b) < 32'(NUM_LINES);
    cmd_o.apply = hit && idx_ok;
    cmd_o.bad   = hit && !idx_ok;
    cmd_o.idx   = idx_b;
    cmd_o.lvl   = lvl_b;
  end
endmodule

// File: rtl/irqlvl_bank.sv
module irqlvl_bank
  import irqlvl_pkg::*;
#(
  parameter int NUM_LINES = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  lvl_cmd_t                    cmd_i,
  output logic [NUM_LINES*BYTE_W-1:0] lvl_flat_o,
  output logic [NUM_LINES-1:0]        line_o
);
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    byte_t lvl_q;
    logic  sel;

    assign sel = cmd_i.apply && (cmd_i.idx == BYTE_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   lvl_q <= '0;
      else if (sel) lvl_q <= cmd_i.lvl;
    end

    assign lvl_flat_o[i*BYTE_W +: BYTE_W] = lvl_q;
    assign line_o[i] = |lvl_q;
  end
endmodule

// File: rtl/irqlvl_rdmux.sv
module irqlvl_rdmux
  import irqlvl_pkg::*;
#(
  parameter int NUM_LINES = 4
) (
  input  logic [NUM_LINES*BYTE_W-1:0] lvl_flat_i,
  input  byte_t                       sel_i,
  output byte_t                       lvl_o
);
  always_comb begin
    lvl_o = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (sel_i == BYTE_W'(i)) lvl_o = lvl_flat_i[i*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/irqlvl_top.sv
module irqlvl_top
  import irqlvl_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int ADDR_W    = 12,
  parameter int REG_OFS   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_valid,
  output logic                 wr_ready,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [1:0]           wr_be,
  input  logic [15:0]          wr_data,
  input  logic [7:0]           rd_idx,
  output logic [7:0]           rd_level,
  output logic [NUM_LINES-1:0] irq_lines,
  output logic                 err_pulse
);
  if (NUM_LINES < 1 || NUM_LINES > MAX_LINES) begin : g_bad_cfg
    $error("irqlvl_top: NUM_LINES out of range");
  end

  lvl_cmd_t                    cmd;
  logic [NUM_LINES*BYTE_W-1:0] lvl_flat;
  logic                        err_q;

  assign wr_ready = 1'b1;

  irqlvl_decode #(
    .NUM_LINES(NUM_LINES),
    .ADDR_W   (ADDR_W),
    .REG_OFS  (REG_OFS)
  ) u_decode (
    .valid_i(wr_valid),
    .addr_i (wr_addr),
    .be_i   (wr_be),
    .data_i (wr_data),
    .cmd_o  (cmd)
  );

  irqlvl_bank #(.NUM_LINES(NUM_LINES)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_i     (cmd),
    .lvl_flat_o(lvl_flat),
    .line_o    (irq_lines)
  );

  irqlvl_rdmux #(.NUM_LINES(NUM_LINES)) u_rdmux (
    .lvl_flat_i(lvl_flat),
    .sel_i     (rd_idx),
    .lvl_o     (rd_level)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= cmd.bad;
  end

  assign err_pulse = err_q;
endmodule

// File: rtl/irqlvl_chk.sv
module irqlvl_chk #(
  parameter int NUM_LINES = 4,
  parameter int ADDR_W    = 12,
  parameter int REG_OFS   = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_valid,
  input logic [ADDR_W-1:0]    wr_addr,
  input logic [1:0]           wr_be,
  input logic [15:0]          wr_data,
  input logic [7:0]           rd_idx,
  input logic [7:0]           rd_level,
  input logic [NUM_LINES-1:0] irq_lines,
  input logic                 err_pulse
);
  logic                 at_reg;
  logic                 in_rng;
  logic                 good_wr;
  logic                 bad_wr;
  logic [NUM_LINES-1:0] sel_mask;

  always_comb begin
    at_reg   = wr_valid && ((wr_addr & ADDR_W'('h3f)) == ADDR_W'(REG_OFS));
    in_rng   = 32'(wr_data[15:8]) < 32'(NUM_LINES);
    good_wr  = at_reg && wr_be[1] && in_rng;
    bad_wr   = at_reg && wr_be[1] && !in_rng;
    sel_mask = '0;
    for (int i = 0; i < NUM_LINES; i++)
      if (wr_data[15:8] == 8'(i)) sel_mask[i] = 1'b1;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> (irq_lines == '0 && !err_pulse)); // R1

  AST_OFF_REG_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !at_reg) |=> ($stable(irq_lines) && !err_pulse)); // R2

  AST_SINGLE_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (good_wr && !wr_be[0]) |=> ((irq_lines & $past(sel_mask)) == '0)); // R4

  AST_NO_INDEX_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (at_reg && !wr_be[1]) |=> ($stable(irq_lines) && !err_pulse)); // R4

  AST_LEVEL_SETS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (good_wr && wr_be[0] && wr_data[7:0] != 8'd0) |=> ((irq_lines & $past(sel_mask)) != '0)); // R5

  AST_OTHERS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    good_wr |=> (((irq_lines ^ $past(irq_lines)) & ~$past(sel_mask)) == '0)); // R5

  AST_BAD_INDEX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bad_wr |=> ($stable(irq_lines) && err_pulse)); // R6

  AST_ERR_ONLY_AFTER_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $past(bad_wr)); // R6

  AST_READ_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(rd_idx) >= 32'(NUM_LINES)) |-> (rd_level == 8'd0)); // R7
endmodule

bind irqlvl_top irqlvl_chk #(
  .NUM_LINES(NUM_LINES),
  .ADDR_W   (ADDR_W),
  .REG_OFS  (REG_OFS)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_valid (wr_valid),
  .wr_addr  (wr_addr),
  .wr_be    (wr_be),
  .wr_data  (wr_data),
  .rd_idx   (rd_idx),
  .rd_level (rd_level),
  .irq_lines(irq_lines),
  .err_pulse(err_pulse)
);

// File: tb/irqlvl_top_tb.sv
`timescale 1ns/1ps
module irqlvl_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NL         = 4;
  localparam int AW         = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [AW-1:0] wr_addr = '0;
  logic [1:0]    wr_be = '0;
  logic [15:0]   wr_data = '0;
  logic [7:0]    rd_idx = '0;
  logic [7:0]    rd_level;
  logic [NL-1:0] irq_lines;
  logic          err_pulse;

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] model [NL];

  always #(CLK_PERIOD/2) clk = ~clk;

  irqlvl_top #(.NUM_LINES(NL), .ADDR_W(AW), .REG_OFS(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_be(wr_be), .wr_data(wr_data), .rd_idx(rd_idx),
    .rd_level(rd_level), .irq_lines(irq_lines), .err_pulse(err_pulse)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [NL-1:0] exp_lines();
    logic [NL-1:0] v;
    for (int i = 0; i < NL; i++) v[i] = (model[i] != 8'd0);
    return v;
  endfunction

  // read back every index 0..7 at successive negedges
  task automatic sweep_read(input string req);
    for (int r = 0; r < 8; r++) begin
      @(negedge clk);
      rd_idx = 8'(r);
      #2;
      check(rd_level == ((r < NL) ? model[r] : 8'd0), req, rd_level,
            (r < NL) ? model[r] : 0);
    end
  endtask

  task automatic one_write(input bit v, input logic [AW-1:0] a,
                           input logic [1:0] be, input logic [15:0] d);
    bit         hit;
    bit         bad;
    int         idx;
    logic [7:0] lvl;
    hit = v && ((int'(a) & 'h3f) == 8) && be[1];
    idx = int'(d[15:8]);
    lvl = be[0] ? d[7:0] : 8'd0;
    bad = hit && (idx >= NL);
    @(negedge clk);
    wr_valid = v; wr_addr = a; wr_be = be; wr_data = d;
    rd_idx = d[15:8];
    #2;
    // same-cycle readback shows the old value (R7)
    check(rd_level == ((idx < NL) ? model[idx] : 8'd0), "R7", rd_level,
          (idx < NL) ? model[idx] : 0);
    check(wr_ready == 1'b1, "R8", wr_ready, 1);
    if (hit && !bad) model[idx] = lvl;
    @(negedge clk);
    wr_valid = 1'b0;
    #1;
    check(irq_lines == exp_lines(), hit ? (be[0] ? "R5" : "R4") : "R2",
          irq_lines, exp_lines());
    check(err_pulse == bad, "R6", err_pulse, bad);
    check(rd_level == ((idx < NL) ? model[idx] : 8'd0), "R3", rd_level,
          (idx < NL) ? model[idx] : 0);
    @(negedge clk);
    #1;
    check(err_pulse == 1'b0, "R6", err_pulse, 0);
  endtask

  initial begin
    logic [AW-1:0] addrs [4];
    logic [7:0]    lvls  [5];
    addrs[0] = 12'h008; addrs[1] = 12'h009; addrs[2] = 12'h048; addrs[3] = 12'h010;
    lvls[0] = 8'h00; lvls[1] = 8'h01; lvls[2] = 8'h80; lvls[3] = 8'hff; lvls[4] = 8'h5a;
    for (int i = 0; i < NL; i++) model[i] = 8'd0;
    #(CLK_PERIOD*2 + 1);
    check(irq_lines == '0, "R1", irq_lines, 0);
    check(err_pulse == 1'b0, "R1", err_pulse, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(irq_lines == '0, "R1", irq_lines, 0);
    sweep_read("R1");

    // worked example: 0x0102 drives level 2 onto line 1 (R3)
    one_write(1'b1, 12'h008, 2'b11, 16'h0102);
    check(irq_lines == 4'b0010, "R3", irq_lines, 4'b0010);

    for (int v = 0; v < 2; v++)
      for (int ai = 0; ai < 4; ai++)
        for (int ix = 0; ix < 8; ix++)
          for (int li = 0; li < 5; li++)
            for (int be = 0; be < 4; be++)
              one_write(v[0], addrs[ai], be[1:0], {8'(ix), lvls[(li + ix + be) % 5]});

    // back-to-back bad indexes: pulse per beat (R6)
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = 12'h008; wr_be = 2'b11; wr_data = 16'h0901;
    @(negedge clk);
    wr_data = 16'h0a01;
    #1;
    check(err_pulse == 1'b1, "R6", err_pulse, 1);
    @(negedge clk);
    wr_valid = 1'b0;
    #1;
    check(err_pulse == 1'b1, "R6", err_pulse, 1);
    check(irq_lines == exp_lines(), "R6", irq_lines, exp_lines());
    @(negedge clk);
    #1;
    check(err_pulse == 1'b0, "R6", err_pulse, 0);
    sweep_read("R5");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule